// File: doc/BRIEF.md
# Register Renamer with History Rollback

This block maps architectural register numbers onto a larger pool of physical registers for an out-of-order core. It accepts one instruction per cycle. The two source operands are looked up in a map table, which returns the current physical register and that register's ready bit. When the instruction writes a register, the lowest-numbered free physical register is taken from a free-list bit vector and becomes the new mapping.

Each accepted instruction appends one entry to a circular history buffer. The entry records the sequence number, the destination architectural register, the new and previous physical registers, and a placeholder flag for instructions without a destination. A squash request walks the buffer from the newest end and undoes the younger mappings. A commit request walks it from the oldest end and releases the registers that the committed mappings replaced. Each walk removes one entry per cycle, and the block stalls while a walk is in progress.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i, every mapped register reads as ready, and physical registers ARCH to PHYS-1 are free.
- R2: An accepted instruction with a destination receives the lowest-numbered free physical register on `dst_preg`. Later lookups of that architectural register return it.
- R3: A newly allocated physical register reads as not ready. Source lookups report the map and ready state as it stood at the start of the cycle.
- R4: A write-back of physical register p makes p read as ready from the next cycle onward.
- R5: Every accepted instruction takes one history entry, as a placeholder when it has no destination. When all HDEPTH entries are in use, `stall` is high and nothing is accepted.
- R6: When no physical register is free, an instruction with a destination is stalled. An instruction without a destination is still accepted.
- R7: A squash with sequence number S removes every entry newer than S, starting from the newest. Each removed entry restores its architectural register to the previous physical register and frees the new one.
- R8: Placeholder entries are removed by squash or commit without changing the map or the free list.
- R9: A commit with sequence number C removes entries from the oldest end while their sequence number is at most C. Each removed entry frees its previous physical register.
- R10: A commit is ignored when the oldest entry's sequence number is already greater than C.
- R11: A squash or commit that arrives while the history is empty changes nothing.
- R12: A squash or commit request wins over an instruction in the same cycle, and a squash wins over a commit. `stall` stays high from the request until its walk has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_seq | input | SEQW | Instruction sequence number |
| in_src_a | input | AW | First source architectural register |
| in_src_b | input | AW | Second source architectural register |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | AW | Destination architectural register |
| stall | output | 1 | Instruction not accepted this cycle |
| src_a_preg | output | PW | Physical register of first source |
| src_a_rdy | output | 1 | Ready bit of first source |
| src_b_preg | output | PW | Physical register of second source |
| src_b_rdy | output | 1 | Ready bit of second source |
| dst_preg | output | PW | Allocated physical register, zero without destination |
| wb_valid | input | 1 | Write-back strobe |
| wb_preg | input | PW | Physical register written back |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQW | Youngest surviving sequence number |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQW | Youngest committed sequence number |

## Verification
The bench builds the block with 8 architectural registers, 14 physical registers, an 8-entry history and 8-bit sequence numbers. With only six spare registers, free-list exhaustion is reached after six allocations, before the history fills. A run of placeholders then fills the history, so each stall cause can be seen on its own. The small map allows a full sweep of every architectural register through both lookup ports after each squash, commit and write-back. Repeated allocate-then-commit rounds move the history pointers past their wrap point several times.

// File: rtl/reg_renamer.sv
`timescale 1ns/1ps
module reg_renamer #(
  parameter int ARCH   = 32,
  parameter int PHYS   = 64,
  parameter int HDEPTH = 16,
  parameter int SEQW   = 16,
  localparam int AW = $clog2(ARCH),
  localparam int PW = $clog2(PHYS),
  localparam int HW = $clog2(HDEPTH),
  localparam int CW = $clog2(HDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SEQW-1:0] in_seq,
  input  logic [AW-1:0]   in_src_a,
  input  logic [AW-1:0]   in_src_b,
  input  logic            in_has_dst,
  input  logic [AW-1:0]   in_dst,
  output logic            stall,
  output logic [PW-1:0]   src_a_preg,
  output logic            src_a_rdy,
  output logic [PW-1:0]   src_b_preg,
  output logic            src_b_rdy,
  output logic [PW-1:0]   dst_preg,
  input  logic            wb_valid,
  input  logic [PW-1:0]   wb_preg,
  input  logic            squash_valid,
  input  logic [SEQW-1:0] squash_seq,
  input  logic            commit_valid,
  input  logic [SEQW-1:0] commit_seq
);

  typedef enum logic [1:0] {IDLE, UNDO, RETIRE} mode_t;

  mode_t           mode_q;
  logic [SEQW-1:0] target_q;
  logic [PW-1:0]   map_q [ARCH];
  logic [PHYS-1:0] free_q, rdy_q;
  logic [HW-1:0]   head_q, tail_q;
  logic [CW-1:0]   hcnt;

  logic [SEQW-1:0] h_seq [HDEPTH];
  logic [AW-1:0]   h_arch [HDEPTH];
  logic [PW-1:0]   h_new [HDEPTH];
  logic [PW-1:0]   h_old [HDEPTH];
  logic            h_ph [HDEPTH];

  logic [PW-1:0] pick;
  logic          have_free;
  always_comb begin
    pick = '0;
    have_free = 1'b0;
    for (int i = PHYS - 1; i >= 0; i--)
      if (free_q[i]) begin
        pick = PW'(i);
        have_free = 1'b1;
      end
  end

  wire [HW-1:0] newest = tail_q - 1'b1;
  wire hist_full = (hcnt == CW'(HDEPTH));
  wire hist_some = (hcnt != '0);
  wire undo_pop   = (mode_q == UNDO)   && hist_some && (h_seq[newest] > target_q);
  wire retire_pop = (mode_q == RETIRE) && hist_some && (h_seq[head_q] <= target_q);

  assign stall = (mode_q != IDLE) | squash_valid | commit_valid | hist_full
               | (in_has_dst & ~have_free);
  wire accept = in_valid & ~stall;

  assign src_a_preg = map_q[in_src_a];
  assign src_b_preg = map_q[in_src_b];
  assign src_a_rdy  = rdy_q[map_q[in_src_a]];
  assign src_b_rdy  = rdy_q[map_q[in_src_b]];
  assign dst_preg   = in_has_dst ? pick : '0;

  always_ff @(posedge clk) begin
    if (accept) begin
      h_seq[tail_q]  <= in_seq;
      h_arch[tail_q] <= in_dst;
      h_new[tail_q]  <= pick;
      h_old[tail_q]  <= map_q[in_dst];
      h_ph[tail_q]   <= ~in_has_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= IDLE;
      target_q <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      hcnt     <= '0;
      rdy_q    <= '1;
      for (int i = 0; i < ARCH; i++) map_q[i] <= PW'(i);
      for (int i = 0; i < PHYS; i++) free_q[i] <= (i >= ARCH);
    end else begin
      if (wb_valid) rdy_q[wb_preg] <= 1'b1;
      case (mode_q)
        IDLE: begin
          if (squash_valid) begin
            mode_q   <= UNDO;
            target_q <= squash_seq;
          end else if (commit_valid) begin
            mode_q   <= RETIRE;
            target_q <= commit_seq;
          end else if (accept) begin
            tail_q <= tail_q + 1'b1;
            hcnt   <= hcnt + 1'b1;
            if (in_has_dst) begin
              map_q[in_dst] <= pick;
              free_q[pick]  <= 1'b0;
              rdy_q[pick]   <= 1'b0;
            end
          end
        end
        UNDO: begin
          if (undo_pop) begin
            if (!h_ph[newest]) begin
              map_q[h_arch[newest]] <= h_old[newest];
              free_q[h_new[newest]] <= 1'b1;
            end
            tail_q <= newest;
            hcnt   <= hcnt - 1'b1;
          end else mode_q <= IDLE;
        end
        RETIRE: begin
          if (retire_pop) begin
            if (!h_ph[head_q]) free_q[h_old[head_q]] <= 1'b1;
            head_q <= head_q + 1'b1;
            hcnt   <= hcnt - 1'b1;
          end else mode_q <= IDLE;
        end
        default: mode_q <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/reg_renamer_chk.sv
`timescale 1ns/1ps
module reg_renamer_chk #(
  parameter int ARCH   = 32,
  parameter int PHYS   = 64,
  parameter int HDEPTH = 16,
  localparam int PW = $clog2(PHYS),
  localparam int CW = $clog2(HDEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_has_dst,
  input logic            stall,
  input logic [PW-1:0]   dst_preg,
  input logic            wb_valid,
  input logic [PW-1:0]   wb_preg,
  input logic            squash_valid,
  input logic            commit_valid,
  input logic [PHYS-1:0] free_q,
  input logic [PHYS-1:0] rdy_q,
  input logic [CW-1:0]   hcnt
);

  wire alloc = in_valid && !stall && in_has_dst;

  p_alloc_from_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> free_q[dst_preg]);

  p_alloc_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> !rdy_q[$past(dst_preg)]);

  p_wb_sets_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(alloc && dst_preg == wb_preg)) |=> rdy_q[$past(wb_preg)]);

  p_full_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == CW'(HDEPTH)) |-> stall);

  p_hist_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= CW'(HDEPTH));

  p_free_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_q) <= PHYS - ARCH);

  p_request_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid || commit_valid) |-> stall);

endmodule

bind reg_renamer reg_renamer_chk #(.ARCH(ARCH), .PHYS(PHYS), .HDEPTH(HDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_has_dst(in_has_dst),
  .stall(stall), .dst_preg(dst_preg), .wb_valid(wb_valid), .wb_preg(wb_preg),
  .squash_valid(squash_valid), .commit_valid(commit_valid),
  .free_q(free_q), .rdy_q(rdy_q), .hcnt(hcnt)
);

// File: tb/tb_reg_renamer.sv
`timescale 1ns/1ps
module tb_reg_renamer;
  localparam int ARCH = 8, PHYS = 14, HDEPTH = 8, SEQW = 8;
  localparam int AW = $clog2(ARCH), PW = $clog2(PHYS);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_has_dst = 0, wb_valid = 0, squash_valid = 0, commit_valid = 0;
  logic [SEQW-1:0] in_seq = 0, squash_seq = 0, commit_seq = 0;
  logic [AW-1:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
  logic [PW-1:0] wb_preg = 0;
  logic stall, src_a_rdy, src_b_rdy;
  logic [PW-1:0] src_a_preg, src_b_preg, dst_preg;

  always #2.5 clk = ~clk;

  reg_renamer #(.ARCH(ARCH), .PHYS(PHYS), .HDEPTH(HDEPTH), .SEQW(SEQW)) dut (.*);

  int nchk = 0, nerr = 0, seq_n = 1, last_new = 0;
  bit done = 0;
  int mapm [ARCH];
  bit freem [PHYS];
  bit rdym [PHYS];
  int qs[$], qa[$], qn[$], qo[$];
  bit qp[$];

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lowfree();
    for (int i = 0; i < PHYS; i++) if (freem[i]) return i;
    return -1;
  endfunction

  task automatic clear_in();
    in_valid = 0; in_has_dst = 0; wb_valid = 0; squash_valid = 0; commit_valid = 0;
  endtask

  task automatic issue(bit has, int d, int a, int b, string req);
    bit exp_stall;
    @(negedge clk);
    clear_in();
    in_valid = 1; in_has_dst = has; in_dst = AW'(d); in_seq = SEQW'(seq_n);
    in_src_a = AW'(a); in_src_b = AW'(b);
    #1;
    exp_stall = (qs.size() == HDEPTH) || (has && lowfree() < 0);
    check({req, " stall"}, int'(stall), int'(exp_stall));
    check("R3 lookup a", int'(src_a_preg), mapm[a]);
    check("R3 ready a", int'(src_a_rdy), int'(rdym[mapm[a]]));
    check("R3 lookup b", int'(src_b_preg), mapm[b]);
    check("R3 ready b", int'(src_b_rdy), int'(rdym[mapm[b]]));
    if (!exp_stall && has) check("R2 dst", int'(dst_preg), lowfree());
    @(posedge clk);
    if (!exp_stall) begin
      qs.push_back(seq_n); qa.push_back(d); qp.push_back(!has);
      if (has) begin
        last_new = lowfree();
        qn.push_back(last_new); qo.push_back(mapm[d]);
        mapm[d] = last_new; freem[last_new] = 0; rdym[last_new] = 0;
      end else begin
        qn.push_back(0); qo.push_back(0);
      end
      seq_n++;
    end
  endtask

  task automatic squash_t(int s);
    @(negedge clk);
    clear_in();
    squash_valid = 1; squash_seq = SEQW'(s);
    in_valid = 1; in_has_dst = 0;
    #1;
    check("R12 squash blocks issue", int'(stall), 1);
    @(negedge clk);
    clear_in();
    #1;
    check("R12 stall during walk", int'(stall), 1);
    repeat (HDEPTH + 3) @(negedge clk);
    while (qs.size() > 0 && qs[$] > s) begin
      if (!qp[$]) begin mapm[qa[$]] = qo[$]; freem[qn[$]] = 1; end
      void'(qs.pop_back()); void'(qa.pop_back()); void'(qn.pop_back());
      void'(qo.pop_back()); void'(qp.pop_back());
    end
  endtask

  task automatic commit_t(int c);
    @(negedge clk);
    clear_in();
    commit_valid = 1; commit_seq = SEQW'(c);
    #1;
    check("R12 commit stalls", int'(stall), 1);
    @(negedge clk);
    clear_in();
    repeat (HDEPTH + 3) @(negedge clk);
    while (qs.size() > 0 && qs[0] <= c) begin
      if (!qp[0]) freem[qo[0]] = 1;
      void'(qs.pop_front()); void'(qa.pop_front()); void'(qn.pop_front());
      void'(qo.pop_front()); void'(qp.pop_front());
    end
  endtask

  task automatic wb_t(int p);
    @(negedge clk);
    clear_in();
    wb_valid = 1; wb_preg = PW'(p);
    @(posedge clk);
    rdym[p] = 1;
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < ARCH; a++) begin
      @(negedge clk);
      clear_in();
      in_src_a = AW'(a); in_src_b = AW'(ARCH - 1 - a);
      #1;
      check({req, " map a"}, int'(src_a_preg), mapm[a]);
      check({req, " rdy a"}, int'(src_a_rdy), int'(rdym[mapm[a]]));
      check({req, " map b"}, int'(src_b_preg), mapm[ARCH - 1 - a]);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R12 watchdog: actual 0 expected 1 (run finished)");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ARCH; i++) mapm[i] = i;
    for (int i = 0; i < PHYS; i++) begin freem[i] = (i >= ARCH); rdym[i] = 1; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    sweep("R1");
    // allocation, placeholder, re-mapping of one register
    issue(1, 3, 3, 0, "R2");
    issue(1, 5, 3, 1, "R3");
    issue(0, 0, 5, 2, "R8");
    issue(1, 3, 3, 5, "R2");
    sweep("R3");
    wb_t(8); wb_t(10);
    sweep("R4");
    // squash removes seq 4 and placeholder seq 3
    squash_t(2);
    sweep("R7");
    issue(1, 6, 6, 3, "R7");
    // exhaust the free list
    issue(1, 0, 0, 1, "R6");
    issue(1, 1, 0, 1, "R6");
    issue(1, 2, 1, 2, "R6");
    issue(1, 4, 4, 2, "R6");
    issue(0, 0, 4, 3, "R6");
    issue(0, 0, 2, 6, "R5");
    issue(0, 0, 1, 7, "R5");
    // commit older than every entry: ignored, history stays full
    commit_t(0);
    issue(0, 0, 0, 0, "R10");
    commit_t(2);
    sweep("R9");
    issue(1, 7, 7, 3, "R9");
    squash_t(0);
    sweep("R8");
    squash_t(100);
    commit_t(100);
    sweep("R11");
    issue(1, 2, 2, 2, "R11");
    commit_t(seq_n - 1);
    // rounds of allocate, write back, commit; history pointers wrap
    for (int r = 0; r < 3; r++)
      for (int d = 0; d < ARCH; d++) begin
        issue(1, d, d, (d + r) % ARCH, "R2");
        if (d % 2 == 0) wb_t(last_new);
        issue(0, 0, d, (d + 1) % ARCH, "R5");
        commit_t(seq_n - 1);
      end
    sweep("R9");
    done = 1;
    summary();
    $finish;
  end
endmodule